// File: doc/BRIEF.md
# Sub-coded 8-bit ALU

This block is the arithmetic and logic stage of a small accumulator datapath. A decoder hands it the 4-bit sub-field of the ALU opcode together with a separate shift-mode strobe. The ALU also receives the accumulator value, a byte already fetched from data memory, the instruction's immediate byte and the current carry flag. It is purely combinational. In the same cycle it returns the new result, a write-enable for the accumulator, and the next values of the carry, zero and negative flags. Fetching the memory byte and holding the registers and flags are done outside the block.

Bit 3 of the sub-field picks the operand source. When it is clear, the operand is the fetched memory byte. When it is set, the operand is the immediate byte itself. Bit 2 picks the operation group: arithmetic, or logic and compare. Bits 1:0 pick the operation within that group. When shift-mode is asserted, the sub-field instead selects one of four single-bit shifts or rotates applied to the accumulator.

Top module: `subalu_core`

## Requirements
- R1: With shift_mode low, sub_code[3]=0 takes the operand from mem_data and sub_code[3]=1 takes it from imm_data; the byte that is not selected has no effect on any output.
- R2: With shift_mode low and sub_code[2:0]=000 (ADD), the result is acc+operand and carry_in is ignored. With 001 (ADC), the result is acc+operand+carry_in. In both cases carry_out is the carry out of bit 7.
- R3: With shift_mode low and sub_code[2:0]=010 (SUB), the result is acc-operand and carry_in is ignored. With 011 (SBC), the result is acc-operand-(1-carry_in). In both cases carry_out is 1 exactly when no borrow occurred.
- R4: With shift_mode low and sub_code[2:0] equal to 100 (AND), 101 (OR) or 110 (XOR), the result is the bitwise operation of acc and the operand, and carry_out equals carry_in.
- R5: With shift_mode low and sub_code[2:0]=111 (compare), result is acc-operand, acc_we is 0, and carry_out is 1 exactly when acc >= operand (unsigned).
- R6: With shift_mode high, sub_code[1:0]=00 shifts acc left, 01 shifts it right, 10 rotates it left through carry and 11 rotates it right through carry. The bit shifted out goes to carry_out. The rotates put carry_in into the vacated bit, and the plain shifts put 0 there.
- R7: For every operation, zero_out is 1 exactly when the 8-bit result is zero, and neg_out equals bit 7 of the result.
- R8: acc_we is 1 for every operation except compare.
- R9: With shift_mode high, sub_code[3:2], mem_data and imm_data have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc | input | 8 | Current accumulator value |
| mem_data | input | 8 | Operand byte fetched from data memory |
| imm_data | input | 8 | Immediate byte of the instruction |
| carry_in | input | 1 | Current carry flag |
| sub_code | input | 4 | Sub-field of the ALU opcode |
| shift_mode | input | 1 | Selects the shift/rotate group |
| result | output | 8 | Operation result |
| acc_we | output | 1 | Accumulator write-enable |
| carry_out | output | 1 | Next carry flag |
| zero_out | output | 1 | Next zero flag |
| neg_out | output | 1 | Next negative flag |

## Verification
The bench builds the block with its default data width of 8. At that width the sign bit is bit 7, and the carry and borrow boundaries are 0xFF+1 and 0x00-1, which the directed cases reach on purpose. Tens of thousands of random vectors cover every sub-code under both shift-mode settings and both carry values. Separate directed vectors show that the unselected operand byte and the unused sub-field bits in shift mode leave every output unchanged.

// File: rtl/subalu_pkg.sv
package subalu_pkg;

  typedef enum logic [1:0] {
    SRC_ADDER = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_SHIFT = 2'd2
  } res_src_t;

  localparam logic [1:0] AS_ADD  = 2'b00;
  localparam logic [1:0] AS_ADDC = 2'b01;
  localparam logic [1:0] AS_SUB  = 2'b10;
  localparam logic [1:0] AS_SUBC = 2'b11;

  localparam logic [1:0] LG_AND = 2'b00;
  localparam logic [1:0] LG_OR  = 2'b01;
  localparam logic [1:0] LG_XOR = 2'b10;

  localparam logic [1:0] SH_LEFT  = 2'b00;
  localparam logic [1:0] SH_RIGHT = 2'b01;
  localparam logic [1:0] SH_ROTL  = 2'b10;
  localparam logic [1:0] SH_ROTR  = 2'b11;

endpackage

// File: rtl/subalu_decode.sv
module subalu_decode
  import subalu_pkg::*;
(
  input  logic [3:0] sub_code,
  input  logic       shift_mode,
  output res_src_t   res_src,
  output logic [1:0] adder_sel,
  output logic [1:0] func_sel,
  output logic       use_imm,
  output logic       acc_we
);

  logic is_compare;

  always_comb begin
    is_compare = !shift_mode && (sub_code[2:0] == 3'b111);
    use_imm    = sub_code[3];
    func_sel   = sub_code[1:0];
    acc_we     = !is_compare;
    adder_sel  = sub_code[1:0];
    if (shift_mode) begin
      res_src = SRC_SHIFT;
    end else if (!sub_code[2] || is_compare) begin
      res_src = SRC_ADDER;
      if (is_compare) adder_sel = AS_SUB;
    end else begin
      res_src = SRC_LOGIC;
    end
  end

endmodule

// File: rtl/subalu_addsub.sv
module subalu_addsub
  import subalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int WX = W + 1;

  logic         subtract;
  logic         cin_eff;
  logic [W-1:0] b_eff;
  logic [WX-1:0] total;

  always_comb begin
    subtract = sel[1];
    b_eff    = subtract ? ~b : b;
    unique case (sel)
      AS_ADD:  cin_eff = 1'b0;
      AS_ADDC: cin_eff = cin;
      AS_SUB:  cin_eff = 1'b1;
      default: cin_eff = cin;
    endcase
    total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
    sum   = total[W-1:0];
    cout  = total[W];
  end

endmodule

// File: rtl/subalu_logic.sv
module subalu_logic
  import subalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = a ^ b;
    endcase
  end

endmodule

// File: rtl/subalu_shift.sv
module subalu_shift
  import subalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [1:0]   sel,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout
);

  logic fill;
  logic [W-1:0] left_y;
  logic [W-1:0] right_y;

  assign fill = sel[1] & cin;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bits
      if (g == 0) begin : g_low
        assign left_y[g]  = fill;
        assign right_y[g] = a[g+1];
      end else if (g == W - 1) begin : g_high
        assign left_y[g]  = a[g-1];
        assign right_y[g] = fill;
      end else begin : g_mid
        assign left_y[g]  = a[g-1];
        assign right_y[g] = a[g+1];
      end
    end
  endgenerate

  always_comb begin
    if (sel[0]) begin
      y    = right_y;
      cout = a[0];
    end else begin
      y    = left_y;
      cout = a[W-1];
    end
  end

endmodule

// File: rtl/subalu_core.sv
module subalu_core
  import subalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mem_data,
  input  logic [W-1:0] imm_data,
  input  logic         carry_in,
  input  logic [3:0]   sub_code,
  input  logic         shift_mode,
  output logic [W-1:0] result,
  output logic         acc_we,
  output logic         carry_out,
  output logic         zero_out,
  output logic         neg_out
);

  res_src_t     res_src;
  logic [1:0]   adder_sel;
  logic [1:0]   func_sel;
  logic         use_imm;
  logic [W-1:0] operand;
  logic [W-1:0] adder_y;
  logic         adder_c;
  logic [W-1:0] logic_y;
  logic [W-1:0] shift_y;
  logic         shift_c;

  subalu_decode u_dec (
    .sub_code  (sub_code),
    .shift_mode(shift_mode),
    .res_src   (res_src),
    .adder_sel (adder_sel),
    .func_sel  (func_sel),
    .use_imm   (use_imm),
    .acc_we    (acc_we)
  );

  assign operand = use_imm ? imm_data : mem_data;

  subalu_addsub #(.W(W)) u_add (
    .a   (acc),
    .b   (operand),
    .sel (adder_sel),
    .cin (carry_in),
    .sum (adder_y),
    .cout(adder_c)
  );

  subalu_logic #(.W(W)) u_log (
    .a  (acc),
    .b  (operand),
    .sel(func_sel),
    .y  (logic_y)
  );

  subalu_shift #(.W(W)) u_shf (
    .a   (acc),
    .sel (func_sel),
    .cin (carry_in),
    .y   (shift_y),
    .cout(shift_c)
  );

  always_comb begin
    unique case (res_src)
      SRC_ADDER: begin
        result    = adder_y;
        carry_out = adder_c;
      end
      SRC_SHIFT: begin
        result    = shift_y;
        carry_out = shift_c;
      end
      default: begin
        result    = logic_y;
        carry_out = carry_in;
      end
    endcase
    zero_out = (result == '0);
    neg_out  = result[W-1];
  end

endmodule

// File: rtl/subalu_core_checks.sv
module subalu_core_checks #(
  parameter int W = 8
) (
  input logic [W-1:0] acc,
  input logic [W-1:0] mem_data,
  input logic [W-1:0] imm_data,
  input logic         carry_in,
  input logic [3:0]   sub_code,
  input logic         shift_mode,
  input logic [W-1:0] result,
  input logic         acc_we,
  input logic         carry_out,
  input logic         zero_out,
  input logic         neg_out
);

  logic         known;
  logic [W-1:0] opnd;
  logic [W:0]   wide_sum;

  always_comb begin
    known    = !$isunknown({acc, mem_data, imm_data, carry_in, sub_code, shift_mode});
    opnd     = sub_code[3] ? imm_data : mem_data;
    wide_sum = {1'b0, acc} + {1'b0, opnd};
    if (known) begin
      if (!shift_mode && sub_code[2:0] == 3'b111) begin
        AST_CMP_NO_WRITE: assert (!acc_we);                              // R5
        AST_CMP_CARRY: assert (carry_out == (acc >= opnd));              // R5
      end
      if (shift_mode) begin
        AST_SHIFT_WRITES: assert (acc_we);                               // R8
      end
      if (!shift_mode && sub_code[2:0] == 3'b000) begin
        AST_ADD_SUM: assert ({carry_out, result} == wide_sum);           // R2
      end
      if (!shift_mode && sub_code[2] && sub_code[1:0] != 2'b11) begin
        AST_LOGIC_KEEPS_C: assert (carry_out == carry_in);               // R4
      end
      if (shift_mode && sub_code[0] == 1'b0) begin
        AST_LEFT_CARRY: assert (carry_out == acc[W-1]);                  // R6
      end
      if (shift_mode && sub_code[0] == 1'b1) begin
        AST_RIGHT_CARRY: assert (carry_out == acc[0]);                   // R6
      end
    end
  end

endmodule

bind subalu_core subalu_core_checks #(.W(W)) u_checks (
  .acc       (acc),
  .mem_data  (mem_data),
  .imm_data  (imm_data),
  .carry_in  (carry_in),
  .sub_code  (sub_code),
  .shift_mode(shift_mode),
  .result    (result),
  .acc_we    (acc_we),
  .carry_out (carry_out),
  .zero_out  (zero_out),
  .neg_out   (neg_out)
);

// File: tb/subalu_core_test.sv
`timescale 1ns/1ps
module subalu_core_test;

  logic clk;
  logic rst_n;
  logic [7:0] acc, mem_data, imm_data;
  logic       carry_in;
  logic [3:0] sub_code;
  logic       shift_mode;
  logic [7:0] result;
  logic       acc_we, carry_out, zero_out, neg_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  subalu_core uut (
    .acc(acc), .mem_data(mem_data), .imm_data(imm_data), .carry_in(carry_in),
    .sub_code(sub_code), .shift_mode(shift_mode), .result(result),
    .acc_we(acc_we), .carry_out(carry_out), .zero_out(zero_out), .neg_out(neg_out)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference from the requirements
  task automatic model(input int a, m, i, c, code, sh,
                       output int r, output int we, output int co);
    int op, t;
    op = ((code & 8) != 0) ? i : m;
    we = 1;
    co = c;
    if (sh != 0) begin
      case (code & 3)
        0: begin r = (a * 2) % 256;           co = a / 128; end
        1: begin r = a / 2;                   co = a % 2;   end
        2: begin r = (a * 2) % 256 + c;       co = a / 128; end
        default: begin r = a / 2 + c * 128;   co = a % 2;   end
      endcase
    end else begin
      case (code & 7)
        0: begin t = a + op;     r = t % 256; co = (t > 255) ? 1 : 0; end
        1: begin t = a + op + c; r = t % 256; co = (t > 255) ? 1 : 0; end
        2: begin t = a - op;         r = (t + 256) % 256; co = (t >= 0) ? 1 : 0; end
        3: begin t = a - op - (1 - c); r = (t + 512) % 256; co = (t >= 0) ? 1 : 0; end
        4: r = a & op;
        5: r = a | op;
        6: r = a ^ op;
        default: begin t = a - op; r = (t + 256) % 256; co = (a >= op) ? 1 : 0; we = 0; end
      endcase
    end
  endtask

  function automatic string tag_of(int code, int sh);
    if (sh != 0) return ((code & 12) != 0) ? "R9" : "R6";
    case (code & 7)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5, 6: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run(int a, int m, int i, int c, int code, int sh, string forced);
    int r, we, co;
    string tg;
    @(posedge clk);
    acc = a[7:0]; mem_data = m[7:0]; imm_data = i[7:0]; carry_in = c[0];
    sub_code = code[3:0]; shift_mode = sh[0];
    @(negedge clk);
    model(a, m, i, c, code, sh, r, we, co);
    tg = (forced != "") ? forced : tag_of(code, sh);
    check(tg, "result", int'(result), r);
    check(tg, "carry", int'(carry_out), co);
    check((we == 0) ? "R5" : "R8", "acc_we", int'(acc_we), we);
    check("R7", "zero", int'(zero_out), (r == 0) ? 1 : 0);
    check("R7", "neg", int'(neg_out), r / 128);
  endtask

  initial begin
    rst_n = 0;
    acc = 0; mem_data = 0; imm_data = 0; carry_in = 0; sub_code = 0; shift_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: all-zero inputs give ADD 0+0
    check("R7", "reset zero", int'(zero_out), 1);
    check("R8", "reset we", int'(acc_we), 1);
    check("R2", "reset result", int'(result), 0);
    rst_n = 1;

    // R1 operand source, unselected byte varied
    run(10, 20, 3, 0, 0, 0, "R1");
    run(10, 99, 3, 0, 0, 0, "R1");
    run(10, 20, 3, 0, 8, 0, "R1");
    run(10, 77, 3, 0, 8, 0, "R1");
    // R2 add boundaries
    run(255, 1, 0, 1, 0, 0, "R2");
    run(127, 0, 0, 1, 1, 0, "R2");
    run(200, 0, 100, 1, 9, 0, "R2");
    // R3 subtract boundaries
    run(5, 5, 0, 0, 2, 0, "R3");
    run(5, 5, 0, 0, 3, 0, "R3");
    run(0, 1, 0, 1, 2, 0, "R3");
    run(0, 0, 0, 0, 11, 0, "R3");
    // R4 logic keeps carry
    run(8'hF0, 8'h3C, 0, 1, 4, 0, "R4");
    run(8'hF0, 0, 8'h0F, 0, 13, 0, "R4");
    run(8'hAA, 8'hAA, 0, 1, 6, 0, "R4");
    // R5 compare
    run(3, 3, 0, 0, 7, 0, "R5");
    run(2, 3, 0, 1, 7, 0, "R5");
    run(200, 0, 100, 0, 15, 0, "R5");
    // R6 shifts and rotates
    run(8'h80, 0, 0, 1, 2, 1, "R6");
    run(1, 0, 0, 0, 3, 1, "R6");
    run(8'h81, 0, 0, 1, 0, 1, "R6");
    run(8'h81, 0, 0, 1, 1, 1, "R6");
    // R9 unused bits and operands in shift mode
    run(8'h55, 8'hFF, 8'h12, 1, 14, 1, "R9");
    run(8'h55, 8'h00, 8'hEE, 1, 6, 1, "R9");
    // Random sweep
    for (int k = 0; k < 40000; k++) begin
      run($urandom % 256, $urandom % 256, $urandom % 256, $urandom % 2,
          $urandom % 16, (($urandom % 4) == 0) ? 1 : 0, "");
    end
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #700000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule